// File: doc/BRIEF.md
# TDM Serial Frame Receiver

This block keeps the frame timing for a set of serial time-division-multiplexed input lines and turns the incoming bits into bytes. With the default sizes it serves four lines. Each line carries 32 eight-bit channels per frame. A frame lasts 512 clocks, and every bit occupies two clocks. An active-low frame pulse puts the internal position back to the first bit of channel 0. When no pulse arrives, the position wraps on its own every 512 clocks.

Each line has its own shift register. Bits are taken once per bit cell, most significant bit first. When the eighth bit of a channel has been taken, the byte from every line is latched. The latched bytes are then written one after another into a shared data memory. That memory holds one entry per line and channel. The current channel number and bit number are brought out for the transmit side. A registered read port lets the rest of the switch fetch stored bytes.

Top module: `tdm_rx_frame`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the channel output is 0 and the bit-position output is 7.
- R2: When the frame pulse is sampled low at a clock edge, the next cycle shows channel 0 and bit position 7, and that cycle is the first of the two clocks of a new bit cell.
- R3: Each bit position lasts two clocks. Bit position counts down from 7 to 0, and then the channel increments. In cycle k after alignment, the channel is (k mod 512)/16 and the bit position is 7 - ((k/2) mod 8). With no frame pulse the count wraps from channel 31, bit 0 back to channel 0, bit 7.
- R4: Each input bit is taken at the clock edge that ends the first clock of its cell, so the value on the line during the second clock has no effect. The bit taken while the bit position is 7 becomes the most significant bit of the byte.
- R5: Once bit position 0 of a channel has been taken, the byte from line s is stored at data-memory address {s[1:0], channel[4:0]}, with the line number in the upper two bits. The four lines are written in ascending order on the four clocks that follow.
- R6: A channel that is cut short by a frame pulse is never written. Its memory entry keeps the byte from the last complete reception.
- R7: The read port returns the entry at the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, two periods per bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_n | input | 1 | Active-low frame alignment pulse |
| st_in | input | 4 | One serial data bit per input line |
| rd_addr | input | 7 | Data-memory read address {line, channel} |
| rd_data | output | 8 | Registered read data |
| chan_idx | output | 5 | Current channel number |
| bit_pos | output | 3 | Current bit number within the channel, 7 first |

## Verification
The bench uses the default parameters: four lines, 32 channels, 8-bit words and two clocks per bit. With these values the 512-clock frame is short enough to run several times. That covers a complete frame behind a pulse, a wrap with no pulse, a realignment part-way through a channel, and a reset in the middle of a frame. It also fills all 128 memory entries, so every line-and-channel address is written and read back. On one frame the second clock of every cell carries the inverted bit, which separates the correct sampling point from the wrong one.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int DEF_STREAMS      = 4;
  localparam int DEF_CHANNELS     = 32;
  localparam int DEF_WORD         = 8;
  localparam int DEF_CLKS_PER_BIT = 2;

  // index width that stays at least one bit wide
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing
  import tdm_rx_pkg::*;
#(
  parameter int CHANNELS     = DEF_CHANNELS,
  parameter int WORD         = DEF_WORD,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  localparam int CW = idx_w(CHANNELS),
  localparam int BW = idx_w(WORD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fp_n,
  output logic [CW-1:0] chan,
  output logic [BW-1:0] bpos,
  output logic          sample,
  output logic          last_bit
);
  localparam int PW = idx_w(CLKS_PER_BIT);
  localparam logic [PW-1:0] PH_LAST  = PW'(CLKS_PER_BIT - 1);
  localparam logic [PW-1:0] PH_MID   = PW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BW-1:0] BIT_TOP  = BW'(WORD - 1);
  localparam logic [CW-1:0] CH_LAST  = CW'(CHANNELS - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !fp_n) begin
      ph   <= '0;
      bpos <= BIT_TOP;
      chan <= '0;
    end else if (ph == PH_LAST) begin
      ph <= '0;
      if (bpos == '0) begin
        bpos <= BIT_TOP;
        chan <= (chan == CH_LAST) ? '0 : chan + 1'b1;
      end else begin
        bpos <= bpos - 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign sample   = (ph == PH_MID);
  assign last_bit = (bpos == '0);

  // R2: a low pulse restarts the frame position
  a_r2_realign: assert property (@(posedge clk) disable iff (rst)
    !fp_n |=> (chan == '0 && bpos == BIT_TOP && ph == '0));

  // R3: free-running wrap at the end of the frame
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (fp_n && chan == CH_LAST && bpos == '0 && ph == PH_LAST) |=> (chan == '0 && bpos == BIT_TOP));

  // R3: position holds for the whole bit cell
  a_r3_cell_hold: assert property (@(posedge clk) disable iff (rst)
    (fp_n && ph != PH_LAST) |=> ($stable(bpos) && $stable(chan)));
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_rx_pkg::*;
#(
  parameter int STREAMS  = DEF_STREAMS,
  parameter int CHANNELS = DEF_CHANNELS,
  parameter int WORD     = DEF_WORD,
  localparam int SW = idx_w(STREAMS),
  localparam int CW = idx_w(CHANNELS),
  localparam int AW = SW + CW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STREAMS-1:0] st_in,
  input  logic               sample,
  input  logic               last_bit,
  input  logic [CW-1:0]      chan,
  output logic               we,
  output logic [AW-1:0]      waddr,
  output logic [WORD-1:0]    wdata
);
  localparam logic [SW-1:0] IDX_LAST = SW'(STREAMS - 1);

  logic                             cap;
  logic [STREAMS-1:0][WORD-1:0]     hold_bus;
  logic                             wr_act;
  logic [SW-1:0]                    wr_idx;
  logic [CW-1:0]                    hold_ch;

  assign cap = sample && last_bit;

  for (genvar s = 0; s < STREAMS; s++) begin : g_line
    logic [WORD-1:0] shreg;
    logic [WORD-1:0] held;
    always_ff @(posedge clk) begin
      if (sample) shreg <= {shreg[WORD-2:0], st_in[s]};
      if (cap)    held  <= {shreg[WORD-2:0], st_in[s]};
    end
    assign hold_bus[s] = held;
  end

  // serialise the per-line bytes onto one memory write port
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act  <= 1'b0;
      wr_idx  <= '0;
      hold_ch <= '0;
    end else if (cap) begin
      wr_act  <= 1'b1;
      wr_idx  <= '0;
      hold_ch <= chan;
    end else if (wr_act) begin
      if (wr_idx == IDX_LAST) wr_act <= 1'b0;
      wr_idx <= wr_idx + 1'b1;
    end
  end

  assign we    = wr_act;
  assign waddr = {wr_idx, hold_ch};
  assign wdata = hold_bus[wr_idx];

  // R5: a write burst must finish before the next byte is latched
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    cap |-> !wr_act);

  // R5: lines are written in ascending order
  a_r5_order: assert property (@(posedge clk) disable iff (rst)
    (wr_act && wr_idx != IDX_LAST && !cap) |=> (wr_act && wr_idx == $past(wr_idx) + 1'b1));
endmodule

// File: rtl/tdm_rx_dmem.sv
module tdm_rx_dmem #(
  parameter int AW   = 7,
  parameter int WORD = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [WORD-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [WORD-1:0] rdata
);
  logic [WORD-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R5: write address is always defined when a write happens
  a_r5_waddr_known: assert property (@(posedge clk) we |-> !$isunknown(waddr));
endmodule

// File: rtl/tdm_rx_frame.sv
module tdm_rx_frame
  import tdm_rx_pkg::*;
#(
  parameter int STREAMS      = DEF_STREAMS,
  parameter int CHANNELS     = DEF_CHANNELS,
  parameter int WORD         = DEF_WORD,
  parameter int CLKS_PER_BIT = DEF_CLKS_PER_BIT,
  localparam int SW = idx_w(STREAMS),
  localparam int CW = idx_w(CHANNELS),
  localparam int BW = idx_w(WORD),
  localparam int AW = SW + CW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fp_n,
  input  logic [STREAMS-1:0] st_in,
  input  logic [AW-1:0]      rd_addr,
  output logic [WORD-1:0]    rd_data,
  output logic [CW-1:0]      chan_idx,
  output logic [BW-1:0]      bit_pos
);
  logic            sample;
  logic            last_bit;
  logic            we;
  logic [AW-1:0]   waddr;
  logic [WORD-1:0] wdata;

  tdm_rx_timing #(
    .CHANNELS(CHANNELS), .WORD(WORD), .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_timing (
    .clk(clk), .rst(rst), .fp_n(fp_n),
    .chan(chan_idx), .bpos(bit_pos), .sample(sample), .last_bit(last_bit)
  );

  tdm_rx_deser #(
    .STREAMS(STREAMS), .CHANNELS(CHANNELS), .WORD(WORD)
  ) u_deser (
    .clk(clk), .rst(rst), .st_in(st_in), .sample(sample), .last_bit(last_bit),
    .chan(chan_idx), .we(we), .waddr(waddr), .wdata(wdata)
  );

  tdm_rx_dmem #(.AW(AW), .WORD(WORD)) u_dmem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R6: memory is written only after the last bit of a channel was taken
  a_r6_write_after_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(we) |-> ($past(last_bit) && $past(sample)));
endmodule

// File: tb/tdm_rx_frame_test.sv
module tdm_rx_frame_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp_n = 1'b1;
  logic [3:0] st_in = '0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] chan_idx;
  logic [2:0] bit_pos;

  int total = 0;
  int bad = 0;
  int kc = 0;
  bit finished = 1'b0;
  logic [14:0] sbq[$];

  always #4 clk = ~clk;

  tdm_rx_frame uut (
    .clk(clk), .rst(rst), .fp_n(fp_n), .st_in(st_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .chan_idx(chan_idx), .bit_pos(bit_pos)
  );

  function automatic logic [7:0] pat(input int seed, input int s, input int ch);
    return 8'((seed * 29 + s * 59 + ch * 13) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(input string req, input int ch, input int bp);
    chk(chan_idx == 5'(ch), req, chan_idx, ch);
    chk(bit_pos == 3'(bp), req, bit_pos, bp);
  endtask

  // pulse the frame input; returns in cycle 0 of the new frame
  task automatic align();
    fp_n = 1'b0;
    @(negedge clk);
    fp_n = 1'b1;
    kc = 0;
    chk_pos("R2", 0, 7);
  endtask

  // drive n cycles; push expected bytes for channels of frames >= push_from
  task automatic drive(input int seed, input int n, input int push_from, input bit inv_second);
    for (int i = 0; i < n; i++) begin
      int kk = kc % 512;
      int fr = kc / 512;
      if (kk % 64 == 0) chk_pos("R3", kk / 16, 7 - (kk / 2) % 8);
      for (int s = 0; s < 4; s++) begin
        logic [7:0] b = pat(seed + fr, s, kk / 16);
        logic bitv = b[7 - (kk / 2) % 8];
        st_in[s] = (inv_second && (kk % 2 == 1)) ? ~bitv : bitv;
      end
      if (fr >= push_from && kk % 16 == 15)
        for (int s = 0; s < 4; s++)
          sbq.push_back({7'(s * 32 + kk / 16), pat(seed + fr, s, kk / 16)});
      @(negedge clk);
      kc++;
    end
  endtask

  // monitor: pop expected items and compare against the read port (R5, R7)
  task automatic drain(input string req);
    while (sbq.size() > 0) begin
      logic [14:0] it = sbq.pop_front();
      rd_addr = it[14:8];
      @(negedge clk);
      kc++;
      chk(rd_data == it[7:0], req, rd_data, it[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_pos("R1 in reset", 0, 7);
    rst = 1'b0;
    chk_pos("R1 after release", 0, 7);
    repeat (5) @(negedge clk);

    // one aligned frame
    align();
    drive(10, 512, 0, 1'b0);
    drain("R5 R7 frame one");

    // two frames without pulse, second half of each cell inverted
    align();
    drive(40, 1024, 1, 1'b1);
    drain("R3 R4 wrap and sample point");

    // realign part-way through channel 9
    align();
    drive(70, 16 * 9 + 6, 0, 1'b0);
    align();
    drain("R5 before realign");
    for (int s = 0; s < 4; s++) begin
      rd_addr = 7'(s * 32 + 9);
      @(negedge clk);
      chk(rd_data == pat(41, s, 9), "R6 cut channel kept", rd_data, pat(41, s, 9));
    end

    // reset in mid frame, then a full frame
    align();
    drive(90, 200, 99, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk_pos("R1 mid reset", 0, 7);
    rst = 1'b0;
    kc = 0;
    chk_pos("R1 release", 0, 7);
    drive(120, 512, 0, 1'b0);
    drain("R5 R7 after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule